// File: doc/BRIEF.md
# Debug Scan Command Sequencer

This block sits between a debug host and a TAP shift engine and turns high-level debug commands into a series of scan requests. A command is one of four kinds: TAP reset, chain selection, register read or register write. The block remembers which scan chain is active. It builds the data-register frame for that chain, including its CRC, and hands each frame to the shift engine as a request that carries a kind, a bit length and the shift-in data. Each completion from the engine returns the shift-out data.

Reads take two full data scans. The first scan loads the addressed value in the target, and the second scan returns it. Every read scan is repeated until the CRC carried in the returned frame matches the CRC recomputed over the returned bits. Writes take one scan and ignore what comes back. A chain selection costs three scans, or none when the chain asked for is already the active one.

Top module: `dbg_host_seq`

## Requirements
- R1: After reset, cmd_ready is 1 and busy, scan_valid and rsp_valid are 0.
- R2: A TAP reset command (cmd_op 0) issues exactly one scan of kind 0 (TAP reset). It also forgets the active chain, so the next chain selection runs in full whatever chain it names.
- R3: A select command (cmd_op 1) naming the chain already active issues no scan and never raises busy.
- R4: A select command naming any other chain issues three scans, in this order: kind 1 (instruction) of length 4 with value 4'h3; then kind 2 (data) of length 12 with the chain number in bits [3:0] and its CRC in bits [11:4]; then kind 1 of length 4 with value 4'h8.
- R5: Every CRC is 8 bits. It is computed over bits 0 upward from a zero start. For each data bit b, the new value is {c[6:2], b^c[1]^c[7], b^c[0]^c[7], b^c[7]}.
- R6: On chain 4 a frame is 46 bits long: address in [4:0], write flag in [5], data in [37:6] and CRC over [37:0] in [45:38].
- R7: On every other chain a frame is 73 bits long: address in [31:0], write flag in [32], data in [64:33] and CRC over [64:0] in [72:65].
- R8: A write (cmd_op 3) issues a single data scan (kind 2) with the write flag set and the command data in the data field. It produces no response.
- R9: A read (cmd_op 2) issues data scans with the write flag and the data field at zero. The first good scan's data is discarded. The returned value is the data field of the second good scan, delivered on rsp_rdata with a one-cycle rsp_valid.
- R10: A read scan whose returned CRC does not match the recomputed CRC is issued again with identical contents, until the CRCs match.
- R11: While scan_valid is high and scan_ready is low, scan_valid, scan_kind, scan_len and scan_din hold their values.
- R12: busy is high from the cycle after a command is accepted until the final scan completes. cmd_ready is low whenever busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 2 | 0 TAP reset, 1 select, 2 read, 3 write |
| cmd_chain | input | 4 | Chain number for select |
| cmd_addr | input | 32 | Register address for read and write |
| cmd_wdata | input | 32 | Data for write |
| busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 32 | Read data |
| scan_valid | output | 1 | Scan request to the shift engine |
| scan_ready | input | 1 | Shift engine takes the request |
| scan_kind | output | 2 | 0 TAP reset, 1 instruction scan, 2 data scan |
| scan_len | output | 7 | Number of bits to shift |
| scan_din | output | 73 | Shift-in bits, bit 0 first |
| scan_done | input | 1 | Scan completion pulse |
| scan_dout | input | 73 | Shift-out bits, valid with scan_done |

## Verification
The hardest situation to reach from the ports is a read whose scans are corrupted in transit. Some corruptions hit the loading scan and some hit the returning scan, and the first scan also carries stale data that must never reach the response. The bench's shift-engine model keeps a target register file. Its first read scan returns whatever value was latched by the previous read. It can also be told to flip a CRC bit on a chosen number of responses. Random command streams mix these injected faults across chains of both frame sizes, and the bench checks both the number of scans issued and the value returned.

// File: rtl/dbg_host_pkg.sv
package dbg_host_pkg;

  localparam int CRC_W = 8;

  typedef enum logic [1:0] {
    OP_TAP_RESET = 2'd0,
    OP_SELECT    = 2'd1,
    OP_READ      = 2'd2,
    OP_WRITE     = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    SK_TAP_RESET = 2'd0,
    SK_IR        = 2'd1,
    SK_DR        = 2'd2
  } scan_kind_e;

  // one serial step of the CRC-8, data taken least significant bit first
  function automatic logic [CRC_W-1:0] crc8_step(input logic [CRC_W-1:0] c, input logic b);
    return {c[6:2], b ^ c[1] ^ c[7], b ^ c[0] ^ c[7], b ^ c[7]};
  endfunction

endpackage

// File: rtl/dbg_crc8.sv
module dbg_crc8
  import dbg_host_pkg::*;
#(
  parameter int MAX_W = 65,
  parameter int CNT_W = 7
) (
  input  logic [MAX_W-1:0] data_i,
  input  logic [CNT_W-1:0] nbits_i,
  output logic [CRC_W-1:0] crc_o
);

  // unrolled serial CRC, only the low nbits_i bits take part
  always_comb begin
    crc_o = '0;
    for (int i = 0; i < MAX_W; i++) begin
      if (i < int'(nbits_i)) crc_o = crc8_step(crc_o, data_i[i]);
    end
  end

endmodule

// File: rtl/dbg_frame_build.sv
module dbg_frame_build
  import dbg_host_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int SHORT_ADDR_W = 5,
  parameter int LONG_ADDR_W  = 32,
  parameter int FRAME_W      = 73,
  parameter int LEN_W        = 7
) (
  input  logic                   short_i,
  input  logic                   wr_i,
  input  logic [LONG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]      data_i,
  output logic [FRAME_W-1:0]     frame_o,
  output logic [LEN_W-1:0]       len_o
);

  localparam int SHORT_BODY = SHORT_ADDR_W + 1 + DATA_W;
  localparam int LONG_BODY  = LONG_ADDR_W + 1 + DATA_W;

  logic [LONG_BODY-1:0] body;
  logic [LEN_W-1:0]     blen;
  logic [CRC_W-1:0]     crc;

  always_comb begin
    body = '0;
    if (short_i) begin
      body[SHORT_ADDR_W-1:0]         = addr_i[SHORT_ADDR_W-1:0];
      body[SHORT_ADDR_W]             = wr_i;
      body[SHORT_ADDR_W+1 +: DATA_W] = data_i;
      blen                           = LEN_W'(SHORT_BODY);
    end else begin
      body[LONG_ADDR_W-1:0]          = addr_i;
      body[LONG_ADDR_W]              = wr_i;
      body[LONG_ADDR_W+1 +: DATA_W]  = data_i;
      blen                           = LEN_W'(LONG_BODY);
    end
  end

  dbg_crc8 #(.MAX_W(LONG_BODY), .CNT_W(LEN_W)) u_crc (
    .data_i (body),
    .nbits_i(blen),
    .crc_o  (crc)
  );

  assign frame_o = FRAME_W'(body) | (FRAME_W'(crc) << blen);
  assign len_o   = blen + LEN_W'(CRC_W);

endmodule

// File: rtl/dbg_rsp_check.sv
module dbg_rsp_check
  import dbg_host_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int SHORT_ADDR_W = 5,
  parameter int LONG_ADDR_W  = 32,
  parameter int FRAME_W      = 73,
  parameter int LEN_W        = 7
) (
  input  logic               short_i,
  input  logic [FRAME_W-1:0] dout_i,
  output logic               crc_ok_o,
  output logic [DATA_W-1:0]  rdata_o
);

  localparam int SHORT_BODY = SHORT_ADDR_W + 1 + DATA_W;
  localparam int LONG_BODY  = LONG_ADDR_W + 1 + DATA_W;

  logic [LEN_W-1:0] blen;
  logic [CRC_W-1:0] crc_calc;
  logic [CRC_W-1:0] crc_rx;

  assign blen = short_i ? LEN_W'(SHORT_BODY) : LEN_W'(LONG_BODY);

  dbg_crc8 #(.MAX_W(LONG_BODY), .CNT_W(LEN_W)) u_crc (
    .data_i (dout_i[LONG_BODY-1:0]),
    .nbits_i(blen),
    .crc_o  (crc_calc)
  );

  assign crc_rx   = CRC_W'(dout_i >> blen);
  assign crc_ok_o = (crc_rx == crc_calc);
  assign rdata_o  = DATA_W'(dout_i >> (blen - LEN_W'(DATA_W)));

endmodule

// File: rtl/dbg_host_seq.sv
module dbg_host_seq
  import dbg_host_pkg::*;
#(
  parameter int IR_W         = 4,
  parameter int CHAIN_W      = 4,
  parameter int DATA_W       = 32,
  parameter int SHORT_ADDR_W = 5,
  parameter int LONG_ADDR_W  = 32,
  parameter logic [IR_W-1:0]    IR_CHAIN_SEL = 'h3,
  parameter logic [IR_W-1:0]    IR_DEBUG     = 'h8,
  parameter logic [CHAIN_W-1:0] SHORT_CHAIN  = 'd4,
  localparam int FRAME_W = LONG_ADDR_W + 1 + DATA_W + CRC_W,
  localparam int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [1:0]             cmd_op,
  input  logic [CHAIN_W-1:0]     cmd_chain,
  input  logic [LONG_ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0]      cmd_wdata,
  output logic                   busy,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic                   scan_valid,
  input  logic                   scan_ready,
  output logic [1:0]             scan_kind,
  output logic [LEN_W-1:0]       scan_len,
  output logic [FRAME_W-1:0]     scan_din,
  input  logic                   scan_done,
  input  logic [FRAME_W-1:0]     scan_dout
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_ISSUE, ST_WAIT} st_e;

  st_e                   state;
  cmd_op_e               op_q;
  logic [1:0]            step_q;
  logic [CHAIN_W-1:0]    chain_q;
  logic                  chain_vld_q;
  logic [LONG_ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]     wdata_q;

  logic                  is_short;
  logic [FRAME_W-1:0]    reg_frame;
  logic [LEN_W-1:0]      reg_len;
  logic                  crc_ok;
  logic [DATA_W-1:0]     rd_field;
  logic [CRC_W-1:0]      chain_crc;
  logic                  sel_noop;

  assign is_short  = (chain_q == SHORT_CHAIN);
  assign cmd_ready = (state == ST_IDLE);
  assign sel_noop  = (cmd_op == OP_SELECT) && chain_vld_q && (cmd_chain == chain_q);

  dbg_frame_build #(
    .DATA_W(DATA_W), .SHORT_ADDR_W(SHORT_ADDR_W), .LONG_ADDR_W(LONG_ADDR_W),
    .FRAME_W(FRAME_W), .LEN_W(LEN_W)
  ) u_build (
    .short_i(is_short),
    .wr_i   (op_q == OP_WRITE),
    .addr_i (addr_q),
    .data_i (op_q == OP_WRITE ? wdata_q : '0),
    .frame_o(reg_frame),
    .len_o  (reg_len)
  );

  dbg_rsp_check #(
    .DATA_W(DATA_W), .SHORT_ADDR_W(SHORT_ADDR_W), .LONG_ADDR_W(LONG_ADDR_W),
    .FRAME_W(FRAME_W), .LEN_W(LEN_W)
  ) u_check (
    .short_i (is_short),
    .dout_i  (scan_dout),
    .crc_ok_o(crc_ok),
    .rdata_o (rd_field)
  );

  dbg_crc8 #(.MAX_W(CHAIN_W), .CNT_W(LEN_W)) u_chain_crc (
    .data_i (chain_q),
    .nbits_i(LEN_W'(CHAIN_W)),
    .crc_o  (chain_crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      op_q        <= OP_TAP_RESET;
      step_q      <= '0;
      chain_q     <= '0;
      chain_vld_q <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      busy        <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      scan_valid  <= 1'b0;
      scan_kind   <= SK_TAP_RESET;
      scan_len    <= '0;
      scan_din    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q    <= cmd_op_e'(cmd_op);
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
            step_q  <= '0;
            if (cmd_op == OP_SELECT) begin
              if (!sel_noop) begin
                chain_q     <= cmd_chain;
                chain_vld_q <= 1'b1;
                busy        <= 1'b1;
                state       <= ST_LOAD;
              end
            end else begin
              if (cmd_op == OP_TAP_RESET) chain_vld_q <= 1'b0;
              busy  <= 1'b1;
              state <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          scan_valid <= 1'b1;
          state      <= ST_ISSUE;
          case (op_q)
            OP_TAP_RESET: begin
              scan_kind <= SK_TAP_RESET;
              scan_len  <= '0;
              scan_din  <= '0;
            end
            OP_SELECT: begin
              if (step_q == 2'd1) begin
                scan_kind <= SK_DR;
                scan_len  <= LEN_W'(CHAIN_W + CRC_W);
                scan_din  <= FRAME_W'({chain_crc, chain_q});
              end else begin
                scan_kind <= SK_IR;
                scan_len  <= LEN_W'(IR_W);
                scan_din  <= FRAME_W'((step_q == 2'd0) ? IR_CHAIN_SEL : IR_DEBUG);
              end
            end
            default: begin
              scan_kind <= SK_DR;
              scan_len  <= reg_len;
              scan_din  <= reg_frame;
            end
          endcase
        end
        ST_ISSUE: begin
          if (scan_ready) begin
            scan_valid <= 1'b0;
            state      <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (scan_done) begin
            case (op_q)
              OP_SELECT: begin
                if (step_q == 2'd2) begin
                  busy  <= 1'b0;
                  state <= ST_IDLE;
                end else begin
                  step_q <= step_q + 2'd1;
                  state  <= ST_LOAD;
                end
              end
              OP_READ: begin
                if (!crc_ok) begin
                  scan_valid <= 1'b1;
                  state      <= ST_ISSUE;
                end else if (step_q == 2'd0) begin
                  step_q     <= 2'd1;
                  scan_valid <= 1'b1;
                  state      <= ST_ISSUE;
                end else begin
                  rsp_valid <= 1'b1;
                  rsp_rdata <= rd_field;
                  busy      <= 1'b0;
                  state     <= ST_IDLE;
                end
              end
              default: begin
                busy  <= 1'b0;
                state <= ST_IDLE;
              end
            endcase
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // request fields stay put until the shift engine takes them
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    scan_valid && !scan_ready |=> scan_valid && $stable(scan_din) && $stable(scan_len) && $stable(scan_kind));

  assert_busy_scan_R12: assert property (@(posedge clk) disable iff (rst)
    scan_valid |-> busy && !cmd_ready);

  assert_noop_select_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && cmd_op == OP_SELECT && chain_vld_q && cmd_chain == chain_q
    |=> !busy && !scan_valid);

  assert_rsp_read_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> op_q == OP_READ && !busy && cmd_ready);

  assert_retry_same_R10: assert property (@(posedge clk) disable iff (rst)
    state == ST_WAIT && scan_done && op_q == OP_READ && !crc_ok |=> scan_valid && $stable(scan_din));

  assert_write_flag_R8: assert property (@(posedge clk) disable iff (rst)
    scan_valid && scan_kind == SK_DR && (op_q == OP_WRITE || op_q == OP_READ)
    |-> scan_din[is_short ? SHORT_ADDR_W : LONG_ADDR_W] == (op_q == OP_WRITE));

endmodule

// File: tb/dbg_host_seq_bench.sv
module dbg_host_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [3:0]  cmd_chain = '0;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        busy, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        scan_valid;
  logic        scan_ready;
  logic [1:0]  scan_kind;
  logic [6:0]  scan_len;
  logic [72:0] scan_din;
  logic        scan_done;
  logic [72:0] scan_dout;

  always #4 clk = ~clk;

  dbg_host_seq u_dbg_host_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_chain(cmd_chain), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .scan_valid(scan_valid),
    .scan_ready(scan_ready), .scan_kind(scan_kind), .scan_len(scan_len),
    .scan_din(scan_din), .scan_done(scan_done), .scan_dout(scan_dout)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input logic [72:0] act, input logic [72:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8_f(input logic [72:0] d, input int n);
    logic [7:0] c = '0;
    for (int i = 0; i < n; i++)
      c = {c[6:2], d[i] ^ c[1] ^ c[7], d[i] ^ c[0] ^ c[7], d[i] ^ c[7]};
    return c;
  endfunction

  function automatic logic [72:0] frame_f(input bit sh, input bit wr, input logic [31:0] a, input logic [31:0] d);
    logic [72:0] f = '0;
    int aw = sh ? 5 : 32;
    int bl = aw + 33;
    logic [7:0] c;
    for (int i = 0; i < aw; i++) f[i] = a[i];
    f[aw] = wr;
    for (int i = 0; i < 32; i++) f[aw + 1 + i] = d[i];
    c = crc8_f(f, bl);
    for (int i = 0; i < 8; i++) f[bl + i] = c[i];
    return f;
  endfunction

  // shift-engine and target model
  logic [1:0]  log_kind [16];
  int          log_len  [16];
  logic [72:0] log_din  [16];
  int          log_n = 0;
  int          inject = 0;
  logic [31:0] m_reg [32];
  logic [31:0] m_lng [32];
  logic [31:0] exp_reg [32];
  logic [31:0] exp_lng [32];
  logic [31:0] m_lat = 32'hDEAD_BEEF;
  logic [3:0]  m_ir = '0;
  logic [3:0]  m_chain = '0;
  logic [72:0] m_din, m_dout, m_first;
  logic [31:0] m_addr, m_data;
  int          m_aw, m_bl;
  bit          m_sh;

  initial begin
    for (int i = 0; i < 32; i++) begin
      m_reg[i] = 32'hA500_0000 ^ (i * 32'h0101_0101);
      exp_reg[i] = m_reg[i];
      m_lng[i] = 32'h5A00_0000 ^ (i * 32'h0011_0011);
      exp_lng[i] = m_lng[i];
    end
    scan_ready = 1'b0;
    scan_done = 1'b0;
    scan_dout = '0;
    forever begin
      @(negedge clk);
      if (scan_valid) begin
        m_first = scan_din;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        check(scan_valid && scan_din == m_first, "R11", scan_din, m_first);
        m_din = scan_din;
        if (log_n < 16) begin
          log_kind[log_n] = scan_kind;
          log_len[log_n] = int'(scan_len);
          log_din[log_n] = scan_din;
        end
        log_n++;
        scan_ready = 1'b1;
        @(negedge clk);
        scan_ready = 1'b0;
        m_dout = '0;
        if (log_kind[(log_n - 1) % 16] == 2'd0) m_ir = '0;
        else if (log_kind[(log_n - 1) % 16] == 2'd1) m_ir = m_din[3:0];
        else if (m_ir == 4'h3) m_chain = m_din[3:0];
        else if (m_ir == 4'h8) begin
          m_sh = (m_chain == 4'd4);
          m_aw = m_sh ? 5 : 32;
          m_bl = m_aw + 33;
          m_addr = '0;
          for (int i = 0; i < m_aw; i++) m_addr[i] = m_din[i];
          for (int i = 0; i < 32; i++) m_data[i] = m_din[m_aw + 1 + i];
          if (m_din[m_aw]) begin
            if (m_sh) m_reg[m_addr[4:0]] = m_data;
            else m_lng[m_addr[4:0]] = m_data;
          end else begin
            m_dout = frame_f(m_sh, 1'b0, m_addr, m_lat);
            m_lat = m_sh ? m_reg[m_addr[4:0]] : m_lng[m_addr[4:0]];
            if (inject > 0) begin
              m_dout[m_bl] = ~m_dout[m_bl];
              inject--;
            end
          end
        end
        repeat ($urandom_range(1, 3)) @(negedge clk);
        scan_dout = m_dout;
        scan_done = 1'b1;
        @(negedge clk);
        scan_done = 1'b0;
      end
    end
  end

  bit busy_seen = 0;
  bit rsp_seen = 0;
  logic [31:0] rsp_cap = '0;
  always @(negedge clk) begin
    if (busy) busy_seen = 1;
    if (rsp_valid) begin
      rsp_seen = 1;
      rsp_cap = rsp_rdata;
    end
  end

  logic [3:0] exp_ch = '0;
  bit exp_vld = 0;

  task automatic do_cmd(input logic [1:0] op, input logic [3:0] ch, input logic [31:0] a,
                        input logic [31:0] wd, input int inj);
    bit noop = (op == 2'd1) && exp_vld && (ch == exp_ch);
    bit sh = (exp_ch == 4'd4);
    int exp_n;
    logic [72:0] ef;
    @(negedge clk);
    log_n = 0;
    inject = inj;
    busy_seen = 0;
    rsp_seen = 0;
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_chain = ch;
    cmd_addr = a;
    cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!noop) check(busy && !cmd_ready, "R12 busy after accept", {71'd0, busy, cmd_ready}, 73'd2);
    while (busy) @(negedge clk);
    @(negedge clk);
    check(!busy && cmd_ready, "R12 idle at end", {71'd0, busy, cmd_ready}, 73'd1);
    case (op)
      2'd0: begin
        exp_vld = 0;
        check(log_n == 1, "R2 scan count", 73'(log_n), 73'd1);
        check(log_kind[0] == 2'd0, "R2 kind", 73'(log_kind[0]), 73'd0);
      end
      2'd1: begin
        if (noop) begin
          check(log_n == 0, "R3 scan count", 73'(log_n), 73'd0);
          check(!busy_seen, "R3 busy", 73'(busy_seen), 73'd0);
        end else begin
          exp_ch = ch;
          exp_vld = 1;
          check(log_n == 3, "R4 scan count", 73'(log_n), 73'd3);
          check(log_kind[0] == 2'd1 && log_len[0] == 4 && log_din[0] == 73'h3, "R4 first", log_din[0], 73'h3);
          ef = 73'({crc8_f(73'(ch), 4), ch});
          check(log_kind[1] == 2'd2 && log_len[1] == 12 && log_din[1] == ef, "R4/R5 chain frame", log_din[1], ef);
          check(log_kind[2] == 2'd1 && log_len[2] == 4 && log_din[2] == 73'h8, "R4 third", log_din[2], 73'h8);
        end
      end
      2'd3: begin
        ef = frame_f(sh, 1'b1, a, wd);
        check(log_n == 1, "R8 scan count", 73'(log_n), 73'd1);
        check(log_kind[0] == 2'd2 && log_din[0] == ef, sh ? "R6/R8 write frame" : "R7/R8 write frame", log_din[0], ef);
        check(log_len[0] == (sh ? 46 : 73), sh ? "R6 length" : "R7 length", 73'(log_len[0]), sh ? 73'd46 : 73'd73);
        check(!rsp_seen, "R8 no response", 73'(rsp_seen), 73'd0);
        if (sh) exp_reg[a[4:0]] = wd;
        else exp_lng[a[4:0]] = wd;
      end
      default: begin
        exp_n = 2 + inj;
        ef = frame_f(sh, 1'b0, a, 32'd0);
        check(log_n == exp_n, inj > 0 ? "R10 scan count" : "R9 scan count", 73'(log_n), 73'(exp_n));
        for (int i = 0; i < exp_n && i < 16; i++)
          check(log_kind[i] == 2'd2 && log_din[i] == ef, "R9 read frame", log_din[i], ef);
        check(rsp_seen && rsp_cap == (sh ? exp_reg[a[4:0]] : exp_lng[a[4:0]]),
              inj > 0 ? "R10 read data" : "R9 read data", 73'(rsp_cap),
              73'(sh ? exp_reg[a[4:0]] : exp_lng[a[4:0]]));
      end
    endcase
  endtask

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cmd_ready && !busy && !scan_valid && !rsp_valid, "R1 reset state",
          {69'd0, cmd_ready, busy, scan_valid, rsp_valid}, 73'h8);
    // directed corner cases
    do_cmd(2'd0, 4'd0, 0, 0, 0);
    do_cmd(2'd1, 4'd4, 0, 0, 0);
    do_cmd(2'd1, 4'd4, 0, 0, 0);                      // R3 repeat select
    do_cmd(2'd3, 4'd0, 32'h7, 32'hCAFE_1234, 0);      // R6 short write
    do_cmd(2'd2, 4'd0, 32'h7, 0, 0);                  // R9 short read
    do_cmd(2'd2, 4'd0, 32'h7, 0, 1);                  // R10 one bad scan
    do_cmd(2'd0, 4'd0, 0, 0, 0);                      // R2 forget chain
    do_cmd(2'd1, 4'd4, 0, 0, 0);
    do_cmd(2'd1, 4'd0, 0, 0, 0);
    do_cmd(2'd3, 4'd0, 32'h1234_5663, 32'h0BAD_F00D, 0); // R7 long write
    do_cmd(2'd2, 4'd0, 32'h1234_5663, 0, 2);          // R10 two bad scans
    do_cmd(2'd2, 4'd0, 32'h0000_0003, 0, 0);
    // random mix
    for (int k = 0; k < 80; k++) begin
      int r = $urandom_range(0, 9);
      int cs = $urandom_range(0, 2);
      logic [3:0] ch = (cs == 0) ? 4'd0 : (cs == 1) ? 4'd1 : 4'd4;
      if (r == 0) do_cmd(2'd0, 4'd0, 0, 0, 0);
      else if (r < 3) do_cmd(2'd1, ch, 0, 0, 0);
      else begin
        if (!exp_vld) do_cmd(2'd1, ch, 0, 0, 0);
        if (r < 6) do_cmd(2'd3, 4'd0, $urandom, $urandom, 0);
        else do_cmd(2'd2, 4'd0, $urandom, 0, $urandom_range(0, 2));
      end
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule